// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Control Register

This block is a single 32-bit control and status word that gathers completion events from six DMA channels into one interrupt request. Each channel owns an enable bit and a sticky pending flag. A completion strobe from a channel is latched into its pending flag only when that channel's enable bit is set. A master enable and a force bit, together with the pending flags and enables, decide a read-only summary bit in the top position of the word.

Software writes the word over a simple register bus. Bits 0 to 23 are ordinary storage and take the written value. Bits 24 to 30 work as write-one-to-clear: a 1 clears the matching pending flag, and a 0 leaves it alone. The block drives one interrupt line. It pulses for one cycle when the summary bit rises. It pulses again after any write that leaves the summary bit set, and when a new enabled completion arrives while the summary bit is already high. This lets a downstream interrupt controller see every new reason to service.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous reset the read word is all zeros and the interrupt line is low.
- R2: A write (wr_en high at a clock edge) stores wr_data bits 0 to 23 unchanged, and they read back from the next cycle on.
- R3: A strobe on channel n (n = 0..5) sets pending flag bit 24+n only if enable bit 16+n held a 1 before that edge. A strobe on a disabled channel leaves the flag at 0.
- R4: Strobes on several channels in the same cycle are all latched.
- R5: On a write, a 1 in bit 24+n clears pending flag n, and a 0 leaves it unchanged. Bit 30 always reads 0.
- R6: When a write clears flag n in the same cycle as an enabled strobe on channel n, the flag ends up set.
- R7: Read bit 31 equals bit15 OR (bit23 AND any channel with both flag and enable set). Writing bit 31 has no effect.
- R8: In the cycle after the edge where bit 31 goes from 0 to 1, the interrupt line is high for exactly one cycle.
- R9: The interrupt line also pulses after a write that leaves bit 31 at 1 (force bit set, or enabled flags still pending with bit 23 set). It also pulses after an enabled strobe that arrives while bit 31 stays at 1.
- R10: The interrupt line stays low when bit 31 ends up 0. It also stays low when bit 31 stays at 1 with no write and no new enabled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| done_strb | input | 6 | Per-channel completion strobes |
| rd_data | output | 32 | Current register value, bit 31 computed |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The bench sweeps every combination of enable mask and strobe mask. A design that read the wrong enable bit, or dropped one of several simultaneous strobes, would show a wrong flag field there. It also sweeps every clear mask against a full set of flags. This catches a flag cleared on a written 0, or a stray bit 30. A write-clear arriving together with a strobe must keep the flag; a design that gave the clear priority would lose the event. The interrupt line is checked for rise pulses, for re-pulses on force writes and on new strobes, and for silence on idle cycles. A level output or a missed re-trigger would fail these checks.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int CH_N      = 6;
    localparam int REG_W     = 32;
    localparam int CTRL_W    = 24;
    localparam int EN_LSB    = 16;
    localparam int FLG_LSB   = 24;
    localparam int FORCE_BIT = 15;
    localparam int MEN_BIT   = 23;
    localparam int SUM_BIT   = 31;
    localparam int FLG_SPAN  = SUM_BIT - FLG_LSB;      // bits 24..30
    localparam int EN_SPAN   = MEN_BIT - EN_LSB;       // bits 16..22
    localparam int MISC_W    = FORCE_BIT;              // bits 0..14

    typedef struct packed {
        logic                master_en;
        logic [EN_SPAN-1:0]  en_field;
        logic                force_irq;
        logic [MISC_W-1:0]   misc;
    } ctrl_t;

    function automatic logic summary_of(input ctrl_t c, input logic [CH_N-1:0] flg);
        return c.force_irq | (c.master_en & (|(flg & c.en_field[CH_N-1:0])));
    endfunction

endpackage

// File: rtl/dirq_flag_bank.sv
module dirq_flag_bank
    import dirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_N-1:0] strb,
    input  logic [CH_N-1:0] en_cur,
    input  logic            clr_en,
    input  logic [CH_N-1:0] clr_bits,
    output logic [CH_N-1:0] flag_q,
    output logic [CH_N-1:0] flag_nxt
);

    for (genvar n = 0; n < CH_N; n++) begin : g_ch
        logic set_now;
        logic clr_now;

        assign set_now     = strb[n] & en_cur[n];
        assign clr_now     = clr_en & clr_bits[n];
        assign flag_nxt[n] = set_now | (flag_q[n] & ~clr_now);

        always_ff @(posedge clk) begin
            if (rst) flag_q[n] <= 1'b0;
            else     flag_q[n] <= flag_nxt[n];
        end

        // R3: a flag only rises after an enabled strobe
        a_r3_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[n]) |-> $past(strb[n] & en_cur[n]));

        // R6: an enabled strobe always leaves the flag set, clear or not
        a_r6_strobe_wins: assert property (@(posedge clk) disable iff (rst)
            $past(strb[n] & en_cur[n]) |-> flag_q[n]);

        // R5: a clear without a strobe leaves the flag low
        a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            $past(clr_en & clr_bits[n] & ~(strb[n] & en_cur[n])) |-> !flag_q[n]);
    end

endmodule

// File: rtl/dirq_master_gen.sv
module dirq_master_gen
    import dirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl_q,
    input  ctrl_t           ctrl_nxt,
    input  logic [CH_N-1:0] flag_q,
    input  logic [CH_N-1:0] flag_nxt,
    input  logic            wr_en,
    input  logic            new_evt,
    output logic            sum_cur,
    output logic            irq_pulse
);

    logic sum_nxt;
    logic irq_q;

    assign sum_cur = summary_of(ctrl_q, flag_q);
    assign sum_nxt = summary_of(ctrl_nxt, flag_nxt);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= sum_nxt & (~sum_cur | wr_en | new_evt);
    end

    assign irq_pulse = irq_q;

    // R8: every rise of the summary bit comes with a pulse
    a_r8_rise_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(sum_cur) |-> irq_q);

    // R10: no pulse without the summary bit
    a_r10_pulse_needs_sum: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> sum_cur);

    // R10: a steady summary bit with no trigger gives no pulse
    a_r10_no_idle_retrigger: assert property (@(posedge clk) disable iff (rst)
        ($past(sum_cur) && !$past(wr_en) && !$past(new_evt)) |-> !irq_q);

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CH_N-1:0]  done_strb,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_pulse
);

    ctrl_t           ctrl_q;
    ctrl_t           ctrl_nxt;
    logic [CH_N-1:0] en_cur;
    logic [CH_N-1:0] flag_q;
    logic [CH_N-1:0] flag_nxt;
    logic            new_evt;
    logic            sum_cur;

    assign ctrl_nxt = wr_en ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    assign en_cur   = ctrl_q.en_field[CH_N-1:0];
    assign new_evt  = |(done_strb & en_cur);

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_nxt;
    end

    dirq_flag_bank u_flags (
        .clk      (clk),
        .rst      (rst),
        .strb     (done_strb),
        .en_cur   (en_cur),
        .clr_en   (wr_en),
        .clr_bits (wr_data[FLG_LSB +: CH_N]),
        .flag_q   (flag_q),
        .flag_nxt (flag_nxt)
    );

    dirq_master_gen u_master (
        .clk       (clk),
        .rst       (rst),
        .ctrl_q    (ctrl_q),
        .ctrl_nxt  (ctrl_nxt),
        .flag_q    (flag_q),
        .flag_nxt  (flag_nxt),
        .wr_en     (wr_en),
        .new_evt   (new_evt),
        .sum_cur   (sum_cur),
        .irq_pulse (irq_pulse)
    );

    always_comb begin
        rd_data                     = '0;
        rd_data[CTRL_W-1:0]         = ctrl_q;
        rd_data[FLG_LSB +: CH_N]    = flag_q;
        rd_data[SUM_BIT]            = sum_cur;
    end

    // R2: a write lands in the low 24 bits unchanged
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (rd_data[CTRL_W-1:0] == $past(wr_data[CTRL_W-1:0])));

    // R5: the spare flag position never reads as set
    a_r5_spare_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[SUM_BIT-1] == 1'b0);

endmodule

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  done_strb = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int total = 0;
    int bad   = 0;

    logic [23:0] m_ctrl = '0;
    logic [5:0]  m_flag = '0;
    logic        m_irq  = 1'b0;

    always #10 clk = ~clk;

    dma_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done_strb (done_strb),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    function automatic logic m_sum(input logic [23:0] c, input logic [5:0] f);
        return c[15] | (c[23] & (|(f & c[21:16])));
    endfunction

    function automatic logic [31:0] m_word();
        return {m_sum(m_ctrl, m_flag), 1'b0, m_flag, m_ctrl};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; entered and left at a falling edge
    task automatic step(input logic wr, input logic [31:0] d, input logic [5:0] s);
        logic [5:0] en_old;
        logic       sum_old;
        logic       evt;
        logic       sum_new;
        en_old  = m_ctrl[21:16];
        sum_old = m_sum(m_ctrl, m_flag);
        evt     = |(s & en_old);
        m_flag  = (m_flag & ~(wr ? d[29:24] : 6'h0)) | (s & en_old);
        if (wr) m_ctrl = d[23:0];
        sum_new = m_sum(m_ctrl, m_flag);
        m_irq   = sum_new & (~sum_old | wr | evt);
        wr_en     = wr;
        wr_data   = d;
        done_strb = s;
        @(posedge clk);
        @(negedge clk);
        wr_en     = 1'b0;
        wr_data   = '0;
        done_strb = '0;
    endtask

    task automatic check_all(input string tag_rd, input string tag_irq);
        check(tag_rd, rd_data, m_word());
        check(tag_irq, {31'b0, irq_pulse}, {31'b0, m_irq});
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 rd", rd_data, 32'h0);
        check("R1 irq", {31'b0, irq_pulse}, 32'h0);

        // R2: low bits store the written value
        step(1'b1, 32'h0012_3456, 6'h0); check_all("R2 rd", "R10 irq");
        step(1'b1, 32'h8041_2A5C, 6'h0); check_all("R2 rd bit31 R7", "R10 irq");
        step(1'b1, 32'h0000_0000, 6'h0); check_all("R2 rd clear", "R10 irq");

        // R3 R4: every enable mask against every strobe mask
        for (int e = 0; e < 64; e++) begin
            for (int s = 0; s < 64; s++) begin
                step(1'b1, 32'h3F80_0000 | (32'(e) << 16), 6'h0);
                check_all("R3 setup", "R10 setup irq");
                step(1'b0, 32'h0, 6'(s));
                check_all("R3 R4 flags", "R8 irq");
                step(1'b0, 32'h0, 6'h0);
                check_all("R4 hold", "R10 idle irq");
            end
        end

        // R5: every clear mask against a full flag set, bit 30 also written
        for (int c = 0; c < 64; c++) begin
            step(1'b1, 32'h003F_0000, 6'h0);
            step(1'b0, 32'h0, 6'h3F);
            check_all("R5 preset", "R10 masked irq");
            step(1'b1, 32'h403F_0000 | (32'(c) << 24), 6'h0);
            check_all("R5 w1c", "R10 w1c irq");
            step(1'b1, 32'h003F_0000, 6'h0);
            check_all("R5 zero keeps", "R10 irq");
        end
        step(1'b1, 32'h3F00_0000, 6'h0);

        // R6: clear and strobe in the same cycle
        step(1'b1, 32'h00BF_0000, 6'h0);
        step(1'b1, 32'h3FBF_0000, 6'h3F);
        check_all("R6 strobe wins", "R8 irq");
        step(1'b1, 32'h3FBF_0000, 6'h05);
        check_all("R6 partial", "R9 write pending irq");

        // R7 R8 R9 R10: master enable, force and re-trigger
        step(1'b1, 32'h3F3F_0000, 6'h0); check_all("R7 men off", "R10 irq");
        step(1'b0, 32'h0, 6'h12);        check_all("R7 pending no men", "R10 irq");
        step(1'b1, 32'h803F_0000, 6'h0); check_all("R7 bit31 write", "R10 irq");
        step(1'b1, 32'h00BF_0000, 6'h0); check_all("R7 men on", "R8 rise");
        step(1'b0, 32'h0, 6'h0);         check_all("R7 hold", "R10 idle");
        step(1'b0, 32'h0, 6'h01);        check_all("R4 extra", "R9 new strobe");
        step(1'b0, 32'h0, 6'h0);         check_all("R7 hold2", "R10 idle2");
        step(1'b1, 32'h3F00_8000, 6'h0); check_all("R7 force", "R9 force write");
        step(1'b1, 32'h0000_8000, 6'h0); check_all("R7 force again", "R9 force repeat");
        step(1'b0, 32'h0, 6'h3F);        check_all("R3 disabled", "R10 no evt");
        step(1'b1, 32'h0000_0000, 6'h0); check_all("R7 force off", "R10 drop");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule